// File: doc/BRIEF.md
# USB Endpoint Event Interrupt Aggregator

This block gathers the event lines of a USB controller core into one 32-bit event word and presents it to a CPU through a small register bus. The event lines are per-endpoint transmit events, per-endpoint receive events, core-level USB causes, and a change of the VBUS-drive level. Each event bit is sticky. Software acknowledges a bit by writing a one to a clear alias, and can inject a bit by writing a one to a set alias. A separate enable mask uses the same pair of aliases. The CPU can read the raw event word, the mask, and the event word ANDed with the mask.

The block drives one interrupt line. It emits a one-cycle pulse when an enabled event is pending and the line is armed. After it fires, the line stays silent until software writes the end-of-interrupt register. Software can therefore drain and acknowledge events at its own pace and then re-arm the line with one write. The block also decodes a soft-reset request for the controller core, a read-only nonzero revision word, and a status bit that shows the live VBUS-drive level.

Top module: `usb_irq_agg`

## Requirements
- R1: After reset, the raw event word and the mask read as zero, irqOut and softRst are low, and the line is armed. A masked event fires without a prior end-of-interrupt write.
- R2: The event word layout is as follows: txEvt[i] sets bit i (bits 4:0), rxEvt[j] sets bit 9+j (bits 12:9), and coreEvt[k] sets bit 16+k (bits 23:16). A VBUS-drive level change sets bit 24. Bit 8 and all bits not named here always read 0, in both the event word and the mask.
- R3: A high input event sets its bit at the next clock edge. The bit stays set until software clears it. If the event and a clear of the same bit arrive in the same cycle, the bit stays set.
- R4: Writing to offset 0x24 sets every event bit whose data bit is 1. Writing to offset 0x28 clears every event bit whose data bit is 1. Data bits that are 0 leave their event bits unchanged.
- R5: Writing to offset 0x30 sets mask bits where the data is 1. Writing to offset 0x34 clears mask bits where the data is 1. Offset 0x2C reads the mask.
- R6: Offset 0x20 reads the raw event word. Offset 0x38 reads the raw event word ANDed with the mask.
- R7: When the line is armed and the masked word becomes nonzero at clock edge E, irqOut is high for exactly the one cycle after edge E+1.
- R8: Once irqOut has pulsed, it does not pulse again until any write to offset 0x3C. It can fire again one edge after that write.
- R9: Writing to offset 0x04 with data bit 0 set drives softRst high for one cycle after the write edge. Writing with data bit 0 clear gives no pulse. Offset 0x04 reads as 0.
- R10: Offset 0x00 reads the nonzero constant REV_ID. Offset 0x08 bit 0 reads the current vbusDrive level and its other bits read 0. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busSel | input | 1 | Bus access valid this cycle |
| busWr | input | 1 | Access is a write |
| busAddr | input | 6 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from busAddr |
| txEvt | input | 5 | Transmit endpoint event lines, endpoint 0 included |
| rxEvt | input | 4 | Receive endpoint event lines, endpoints 1 and up |
| coreEvt | input | 8 | Core-level USB event causes |
| vbusDrive | input | 1 | VBUS-drive level from the core |
| irqOut | output | 1 | Interrupt pulse to the CPU |
| softRst | output | 1 | One-cycle soft-reset request to the core |

## Verification
The set and clear aliases for the event word and the mask are each swept one bit at a time across all 32 positions. These sweeps separate the implemented bits from reserved bits such as bit 8. Each input event line is pulsed alone, which shows that every line lands at its own bit position. A clear of all bits is issued in the same cycle as a hardware event to show that the event wins. Several event/mask pattern pairs with partial overlap check that the masked view is a true AND and not a copy of either operand. The interrupt line is then followed cycle by cycle through one fire, a blocked period with an event still pending, and a re-arm by end-of-interrupt, which separates a level output from a gated pulse.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;

  // bit positions inside the 32-bit event word
  localparam int TX_LSB   = 0;
  localparam int RX_LSB   = 9;   // receive endpoint 0 would sit at bit 8, never used
  localparam int CORE_LSB = 16;

  // register byte offsets
  localparam int OFF_REV     = 'h00;
  localparam int OFF_CTRL    = 'h04;
  localparam int OFF_STAT    = 'h08;
  localparam int OFF_RAW     = 'h20;
  localparam int OFF_SRC_SET = 'h24;
  localparam int OFF_SRC_CLR = 'h28;
  localparam int OFF_MSK     = 'h2C;
  localparam int OFF_MSK_SET = 'h30;
  localparam int OFF_MSK_CLR = 'h34;
  localparam int OFF_MASKED  = 'h38;
  localparam int OFF_EOI     = 'h3C;

  // strobes from decode to datapath
  typedef struct packed {
    logic        srcSet;
    logic        srcClr;
    logic        mskSet;
    logic        mskClr;
    logic        eoi;
    logic        ctrl;
    logic [31:0] data;
  } busStrb_t;

  function automatic logic [31:0] evtValidMask(int txN, int rxN, int coreN);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < txN; i++) m[TX_LSB + i] = 1'b1;
    for (int i = 0; i < rxN; i++) m[RX_LSB + i] = 1'b1;
    for (int i = 0; i <= coreN; i++) m[CORE_LSB + i] = 1'b1; // includes VBUS change bit
    return m;
  endfunction

endpackage

// File: rtl/usb_irq_ctrl.sv
module usb_irq_ctrl
  import usb_irq_pkg::*;
#(
  parameter int          ADDR_W = 6,
  parameter logic [31:0] REV_ID = 32'h0A17_0201
) (
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  input  logic [31:0]       srcQ,
  input  logic [31:0]       mskQ,
  input  logic              vbusDrive,
  output busStrb_t          strb,
  output logic [31:0]       busRdata
);

  logic wrEn;
  assign wrEn = busSel && busWr;

  always_comb begin
    strb        = '0;
    strb.data   = busWdata;
    strb.srcSet = wrEn && (busAddr == ADDR_W'(OFF_SRC_SET));
    strb.srcClr = wrEn && (busAddr == ADDR_W'(OFF_SRC_CLR));
    strb.mskSet = wrEn && (busAddr == ADDR_W'(OFF_MSK_SET));
    strb.mskClr = wrEn && (busAddr == ADDR_W'(OFF_MSK_CLR));
    strb.eoi    = wrEn && (busAddr == ADDR_W'(OFF_EOI));
    strb.ctrl   = wrEn && (busAddr == ADDR_W'(OFF_CTRL));
  end

  always_comb begin
    busRdata = '0;
    if      (busAddr == ADDR_W'(OFF_REV))    busRdata = REV_ID;
    else if (busAddr == ADDR_W'(OFF_STAT))   busRdata = {31'd0, vbusDrive};
    else if (busAddr == ADDR_W'(OFF_RAW))    busRdata = srcQ;
    else if (busAddr == ADDR_W'(OFF_MSK))    busRdata = mskQ;
    else if (busAddr == ADDR_W'(OFF_MASKED)) busRdata = srcQ & mskQ;
  end

endmodule

// File: rtl/usb_irq_datapath.sv
module usb_irq_datapath
  import usb_irq_pkg::*;
#(
  parameter int TX_EP   = 5,
  parameter int RX_EP   = 4,
  parameter int CORE_EV = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  busStrb_t           strb,
  input  logic [TX_EP-1:0]   txEvt,
  input  logic [RX_EP-1:0]   rxEvt,
  input  logic [CORE_EV-1:0] coreEvt,
  input  logic               vbusDrive,
  output logic [31:0]        srcQ,
  output logic [31:0]        mskQ,
  output logic [31:0]        hwEvt,
  output logic               irqOut,
  output logic               softRst
);

  localparam logic [31:0] VALID = evtValidMask(TX_EP, RX_EP, CORE_EV);
  localparam int VBUS_BIT = CORE_LSB + CORE_EV;

  logic        vbusQ;
  logic        armed;
  logic        pending;
  logic [31:0] srcNext;
  logic [31:0] mskNext;

  // place each input line at its field position
  always_comb begin
    hwEvt = '0;
    for (int i = 0; i < TX_EP; i++)   hwEvt[TX_LSB + i]   = txEvt[i];
    for (int i = 0; i < RX_EP; i++)   hwEvt[RX_LSB + i]   = rxEvt[i];
    for (int i = 0; i < CORE_EV; i++) hwEvt[CORE_LSB + i] = coreEvt[i];
    hwEvt[VBUS_BIT] = vbusDrive ^ vbusQ;
  end

  // hardware events are OR-ed in after the clear, so they win
  always_comb begin
    srcNext = srcQ;
    if (strb.srcClr) srcNext = srcNext & ~strb.data;
    if (strb.srcSet) srcNext = srcNext | strb.data;
    srcNext = (srcNext | hwEvt) & VALID;

    mskNext = mskQ;
    if (strb.mskClr) mskNext = mskNext & ~strb.data;
    if (strb.mskSet) mskNext = mskNext | strb.data;
    mskNext = mskNext & VALID;
  end

  assign pending = |(srcQ & mskQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcQ    <= '0;
      mskQ    <= '0;
      vbusQ   <= 1'b0;
      armed   <= 1'b1;
      irqOut  <= 1'b0;
      softRst <= 1'b0;
    end else begin
      srcQ    <= srcNext;
      mskQ    <= mskNext;
      vbusQ   <= vbusDrive;
      irqOut  <= armed && pending;
      softRst <= strb.ctrl && strb.data[0];
      if (armed && pending) armed <= 1'b0;
      else if (strb.eoi)    armed <= 1'b1;
    end
  end

endmodule

// File: rtl/usb_irq_agg.sv
module usb_irq_agg
  import usb_irq_pkg::*;
#(
  parameter int          ADDR_W  = 6,
  parameter int          TX_EP   = 5,
  parameter int          RX_EP   = 4,
  parameter int          CORE_EV = 8,
  parameter logic [31:0] REV_ID  = 32'h0A17_0201
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busSel,
  input  logic               busWr,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [31:0]        busWdata,
  output logic [31:0]        busRdata,
  input  logic [TX_EP-1:0]   txEvt,
  input  logic [RX_EP-1:0]   rxEvt,
  input  logic [CORE_EV-1:0] coreEvt,
  input  logic               vbusDrive,
  output logic               irqOut,
  output logic               softRst
);

  busStrb_t    strb;
  logic [31:0] srcQ;
  logic [31:0] mskQ;
  logic [31:0] hwEvt;

  usb_irq_ctrl #(.ADDR_W(ADDR_W), .REV_ID(REV_ID)) u_ctrl (
    .busSel(busSel), .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
    .srcQ(srcQ), .mskQ(mskQ), .vbusDrive(vbusDrive),
    .strb(strb), .busRdata(busRdata)
  );

  usb_irq_datapath #(.TX_EP(TX_EP), .RX_EP(RX_EP), .CORE_EV(CORE_EV)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .txEvt(txEvt), .rxEvt(rxEvt), .coreEvt(coreEvt), .vbusDrive(vbusDrive),
    .srcQ(srcQ), .mskQ(mskQ), .hwEvt(hwEvt),
    .irqOut(irqOut), .softRst(softRst)
  );

endmodule

// File: rtl/usb_irq_agg_chk.sv
module usb_irq_agg_chk
  import usb_irq_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int TX_EP   = 5,
  parameter int RX_EP   = 4,
  parameter int CORE_EV = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busWdata,
  input logic [31:0]       busRdata,
  input logic              irqOut,
  input logic [31:0]       srcQ,
  input logic [31:0]       mskQ,
  input logic [31:0]       hwEvt
);

  localparam logic [31:0] VALID = evtValidMask(TX_EP, RX_EP, CORE_EV);

  logic wrMskSet, wrMskClr, wrEoi;
  assign wrMskSet = busSel && busWr && (busAddr == ADDR_W'(OFF_MSK_SET));
  assign wrMskClr = busSel && busWr && (busAddr == ADDR_W'(OFF_MSK_CLR));
  assign wrEoi    = busSel && busWr && (busAddr == ADDR_W'(OFF_EOI));

  // tracks whether a pulse has gone out since the last end-of-interrupt
  logic blocked;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       blocked <= 1'b0;
    else if (wrEoi)  blocked <= 1'b0;
    else if (irqOut) blocked <= 1'b1;
  end

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |=> !irqOut); // R7

  AST_NO_REFIRE_BEFORE_EOI: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> !blocked); // R8

  AST_HW_EVENT_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (hwEvt != 0) |=> ((srcQ & $past(hwEvt)) == $past(hwEvt))); // R3

  AST_MASK_SET_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    wrMskSet |=> ((mskQ & $past(busWdata & VALID)) == $past(busWdata & VALID))); // R5

  AST_MASK_CLR_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    wrMskClr |=> ((mskQ & $past(busWdata)) == 0)); // R5

  AST_RESERVED_BIT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !srcQ[RX_LSB-1] && !mskQ[RX_LSB-1]); // R2

  AST_REV_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_W'(OFF_REV)) |-> (busRdata != 0)); // R10

endmodule

bind usb_irq_agg usb_irq_agg_chk #(
  .ADDR_W(ADDR_W), .TX_EP(TX_EP), .RX_EP(RX_EP), .CORE_EV(CORE_EV)
) u_chk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
  .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut),
  .srcQ(srcQ), .mskQ(mskQ), .hwEvt(hwEvt)
);

// File: tb/usb_irq_agg_bench.sv
module usb_irq_agg_bench;

  localparam logic [31:0] VALID  = 32'h01FF_1E1F;
  localparam logic [31:0] REV    = 32'h0A17_0201;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic [5:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [4:0]  txEvt = '0;
  logic [3:0]  rxEvt = '0;
  logic [7:0]  coreEvt = '0;
  logic        vbusDrive = 1'b0;
  logic        irqOut;
  logic        softRst;

  int nRun = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  usb_irq_agg u_usb_irq_agg (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .txEvt(txEvt), .rxEvt(rxEvt),
    .coreEvt(coreEvt), .vbusDrive(vbusDrive), .irqOut(irqOut), .softRst(softRst)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    nRun++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // drives at a falling edge, write lands on the next rising edge, returns at the following falling edge
  task automatic busWrite(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0; busWdata = '0;
  endtask

  task automatic busRead(input logic [5:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic clearAll();
    busWrite(6'h28, 32'hFFFF_FFFF);
    busWrite(6'h34, 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] pa [4];
    logic [31:0] pb [4];
    pa[0] = 32'hFFFF_FFFF; pb[0] = 32'h0000_FFFF;
    pa[1] = 32'h0155_0A15; pb[1] = 32'h00F0_1E03;
    pa[2] = 32'h0100_0001; pb[2] = 32'h0100_0000;
    pa[3] = 32'h00AA_1C0A; pb[3] = 32'h0055_0205;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    busRead(6'h20, rd); check("R1 raw after reset", rd, 0);
    busRead(6'h2C, rd); check("R1 mask after reset", rd, 0);
    busRead(6'h38, rd); check("R1 masked after reset", rd, 0);
    check("R1 irq after reset", {31'd0, irqOut}, 0);
    check("R1 softRst after reset", {31'd0, softRst}, 0);

    // R1 armed at reset: fires without a prior end-of-interrupt
    busWrite(6'h30, 32'h1);
    busWrite(6'h24, 32'h1);
    check("R1 irq not yet", {31'd0, irqOut}, 0);
    @(negedge clk); check("R1 first fire", {31'd0, irqOut}, 1);
    @(negedge clk); check("R7 pulse ends", {31'd0, irqOut}, 0);
    clearAll();

    // R10 constant and status reads
    busRead(6'h00, rd); check("R10 revision", rd, REV);
    busRead(6'h08, rd); check("R10 status low", rd, 0);
    busRead(6'h10, rd); check("R10 unmapped", rd, 0);
    busRead(6'h04, rd); check("R9 control reads zero", rd, 0);

    // R2/R4 source set and clear, every bit position
    for (int i = 0; i < 32; i++) begin
      busWrite(6'h24, 32'h1 << i);
      busRead(6'h20, rd); check("R4 R2 source set bit", rd, (32'h1 << i) & VALID);
      busWrite(6'h28, 32'h1 << i);
      busRead(6'h20, rd); check("R4 source clear bit", rd, 0);
    end
    // R4 clear leaves other bits
    busWrite(6'h24, VALID);
    busWrite(6'h28, 32'h0000_0F0F);
    busRead(6'h20, rd); check("R4 partial clear", rd, VALID & ~32'h0000_0F0F);
    busWrite(6'h28, 32'hFFFF_FFFF);

    // R2/R5 mask set and clear sweep
    for (int i = 0; i < 32; i++) begin
      busWrite(6'h30, 32'h1 << i);
      busRead(6'h2C, rd); check("R5 R2 mask set bit", rd, (32'h1 << i) & VALID);
      busWrite(6'h34, 32'h1 << i);
      busRead(6'h2C, rd); check("R5 mask clear bit", rd, 0);
    end

    // R6 masked view patterns
    for (int p = 0; p < 4; p++) begin
      busWrite(6'h24, pa[p]);
      busWrite(6'h30, pb[p]);
      busRead(6'h20, rd); check("R6 raw view", rd, pa[p] & VALID);
      busRead(6'h38, rd); check("R6 masked view", rd, pa[p] & pb[p] & VALID);
      clearAll();
    end

    // R2/R3 input lines land at their positions
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); txEvt = 5'(1 << i);
      @(negedge clk); txEvt = '0;
      @(negedge clk);
      busRead(6'h20, rd); check("R3 R2 tx event", rd, 32'h1 << i);
      busWrite(6'h28, 32'hFFFF_FFFF);
    end
    for (int j = 0; j < 4; j++) begin
      @(negedge clk); rxEvt = 4'(1 << j);
      @(negedge clk); rxEvt = '0;
      @(negedge clk);
      busRead(6'h20, rd); check("R3 R2 rx event", rd, 32'h1 << (9 + j));
      busWrite(6'h28, 32'hFFFF_FFFF);
    end
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); coreEvt = 8'(1 << k);
      @(negedge clk); coreEvt = '0;
      @(negedge clk);
      busRead(6'h20, rd); check("R3 R2 core event", rd, 32'h1 << (16 + k));
      busWrite(6'h28, 32'hFFFF_FFFF);
    end

    // R3 event and clear in the same cycle: event wins
    busWrite(6'h24, 32'h0000_0003);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = 6'h28; busWdata = 32'hFFFF_FFFF;
    txEvt = 5'b00100;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0; busWdata = '0; txEvt = '0;
    busRead(6'h20, rd); check("R3 event beats clear", rd, 32'h0000_0004);
    busWrite(6'h28, 32'hFFFF_FFFF);

    // R2/R10 VBUS drive change and level
    @(negedge clk); vbusDrive = 1'b1;
    @(negedge clk);
    busRead(6'h20, rd); check("R2 vbus rise event", rd, 32'h0100_0000);
    busRead(6'h08, rd); check("R10 status high", rd, 1);
    busWrite(6'h28, 32'h0100_0000);
    @(negedge clk);
    busRead(6'h20, rd); check("R3 steady level no event", rd, 0);
    vbusDrive = 1'b0;
    @(negedge clk);
    busRead(6'h20, rd); check("R2 vbus fall event", rd, 32'h0100_0000);
    busRead(6'h08, rd); check("R10 status low again", rd, 0);
    busWrite(6'h28, 32'hFFFF_FFFF);

    // R7/R8 gating
    busWrite(6'h3C, 32'h0);            // re-arm
    busWrite(6'h30, 32'hFFFF_FFFF);
    repeat (2) @(negedge clk);
    check("R7 no pending no irq", {31'd0, irqOut}, 0);
    busWrite(6'h24, 32'h0000_0200);
    check("R7 one edge after pending", {31'd0, irqOut}, 0);
    @(negedge clk); check("R7 fires", {31'd0, irqOut}, 1);
    @(negedge clk); check("R7 single cycle", {31'd0, irqOut}, 0);
    busWrite(6'h28, 32'hFFFF_FFFF);
    busWrite(6'h24, 32'h0001_0000);
    for (int c = 0; c < 6; c++) begin
      @(negedge clk); check("R8 blocked before eoi", {31'd0, irqOut}, 0);
    end
    busWrite(6'h3C, 32'h1234_5678);
    check("R8 edge of eoi", {31'd0, irqOut}, 0);
    @(negedge clk); check("R8 fires after eoi", {31'd0, irqOut}, 1);
    @(negedge clk); check("R8 pulse ends", {31'd0, irqOut}, 0);
    clearAll();

    // R9 soft reset
    busWrite(6'h04, 32'h1);
    check("R9 soft reset pulse", {31'd0, softRst}, 1);
    @(negedge clk); check("R9 soft reset ends", {31'd0, softRst}, 0);
    busWrite(6'h04, 32'hFFFF_FFFE);
    check("R9 bit0 clear no pulse", {31'd0, softRst}, 0);
    busRead(6'h04, rd); check("R9 control still zero", rd, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule